// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block is an APB3 slave that raises an interrupt request every X clock cycles. Software chooses X by writing a period register. It can start or stop the timer, and it can force the count back to zero without changing the period. Each expiry of the period produces a single-cycle pulse on the interrupt output. A pulse is used because the processor input it drives is level-sensitive, so a held level would fire the interrupt again after the handler returns. Each expiry also sets a sticky status flag, which stays set until software reads the status register.

There are two copies of the period. The period register holds the value software wrote last. An internal working copy holds the value the counter is using, and it takes the new value only at a wrap or at a count reset. A period change made while the timer runs therefore never shortens or stretches the interval already in progress. The register window is 16 bytes. Only address bits [3:2] select a register, and higher address bits alias onto the same window.

Top module: `tick_timer`

## Requirements
- R1: After reset the timer is stopped, the count is 0, the period register reads 32'hFFFF_FFFF, the status reads 0 and the interrupt output is low.
- R2: The register map decodes address bits [3:2]:
  - 0 is control, with bit 0 = run and bit 1 = count reset. The count-reset bit always reads 0.
  - 1 is the period.
  - 2 is status, with bit 0 = expired.
  - 3 is the current count.
  - Every transfer completes with pready high and pslverr low.
- R3: While running, the count steps 0, 1, ... up to P-1 and then wraps to 0 on the next edge, where P is the working period. The interrupt is high in the cycle that follows each wrap edge. The first pulse after a count reset therefore comes P edges after the write's access edge, and later pulses follow every P cycles.
- R4: Writing run = 0 stops counting. The count holds its value and no further pulses occur.
- R5: A control write with bit 1 set clears the count to 0 on its access edge and loads the working period from the period register. It produces no pulse and leaves the period register unchanged.
- R6: A period write made while running takes effect only at the next wrap or count reset. The interval in progress completes with the old period.
- R7: A period of 0 or 1 acts as 1, and the interrupt is then high in every cycle while running.
- R8: Each expiry gives exactly one cycle of interrupt. With a period of at least 2, the pulse is never wider than one cycle.
- R9: The status bit is set by every wrap and cleared by a read of the status register. If a wrap and a status read fall on the same edge, the status stays set.
- R10: The count register can be read but not written. Writes to offset 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | APB byte address; bits [3:2] decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Always low |
| irq_o | output | 1 | One-cycle pulse per period expiry |

## Verification
Most internal faults move the interrupt edges. A wrong count, a wrong working period or a wrong wrap compare shifts the next pulse, and the shift is visible at the interrupt pin within one period. Because the pin is compared every cycle against a reference model, such a fault is caught on the first cycle where the pulse is early, late or too wide. A fault in the status flag or the period shadow stays hidden until the next register read. The bench therefore reads those registers often during the random phase and directly around each directed corner case.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int AW = 12,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irq_o
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PER  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  logic         run_q, stat_q, irq_q;
  logic [W-1:0] cnt_q, per_sh_q, per_lv_q, lim_m1;

  wire [1:0] sel  = paddr[3:2];
  wire       acc  = psel & penable;
  wire       wr   = acc & pwrite;
  wire       rd   = acc & ~pwrite;
  wire       clr  = wr && (sel == SEL_CTRL) && pwdata[1];
  wire       srd  = rd && (sel == SEL_STAT);

  assign lim_m1 = (per_lv_q <= W'(1)) ? '0 : per_lv_q - W'(1);

  wire wrap = run_q && !clr && (cnt_q >= lim_m1);

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_o   = irq_q;

  always_comb begin
    case (sel)
      SEL_CTRL: prdata = {31'd0, run_q};
      SEL_PER:  prdata = 32'(per_sh_q);
      SEL_STAT: prdata = {31'd0, stat_q};
      default:  prdata = 32'(cnt_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      per_sh_q <= '1;
      per_lv_q <= '1;
      stat_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= wrap;
      if (wr && sel == SEL_CTRL) run_q <= pwdata[0];
      if (wr && sel == SEL_PER) per_sh_q <= pwdata[W-1:0];
      if (clr || wrap) begin
        cnt_q    <= '0;
        per_lv_q <= per_sh_q;
      end else if (run_q) begin
        cnt_q <= cnt_q + W'(1);
      end
      if (wrap) stat_q <= 1'b1;
      else if (srd) stat_q <= 1'b0;
    end
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_m1);

  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr) |=> $stable(cnt_q));

  a_r5_reset_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !irq_o);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && lim_m1 != '0) |=> !irq_o);

  a_r8_pulse_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(run_q));

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !srd) |=> stat_q);

  a_r9_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_q);
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq_o;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_o(irq_o)
  );

  // reference model built from the requirements
  logic        m_run, m_st, m_irq;
  logic [31:0] m_cnt, m_sh, m_lv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_st <= 0; m_irq <= 0;
      m_cnt <= 0; m_sh <= 32'hFFFF_FFFF; m_lv <= 32'hFFFF_FFFF;
    end else begin
      logic [31:0] lm;
      logic        acc, cl, wp;
      acc = psel && penable;
      lm  = (m_lv <= 1) ? 32'd0 : m_lv - 1;
      cl  = acc && pwrite && paddr[3:2] == 2'd0 && pwdata[1];
      wp  = m_run && !cl && m_cnt >= lm;
      m_irq <= wp;
      if (acc && pwrite && paddr[3:2] == 2'd0) m_run <= pwdata[0];
      if (acc && pwrite && paddr[3:2] == 2'd1) m_sh <= pwdata;
      if (cl || wp) begin m_cnt <= 0; m_lv <= m_sh; end
      else if (m_run) m_cnt <= m_cnt + 1;
      if (wp) m_st <= 1;
      else if (acc && !pwrite && paddr[3:2] == 2'd2) m_st <= 0;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return {31'd0, m_run};
      2'd1: return m_sh;
      2'd2: return {31'd0, m_st};
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) chk("R3/R8 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = {8'd0, a}; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = {8'd0, a};
    @(negedge clk);
    penable = 1;
    #1;
    v = prdata;
    chk("R2/R10 read vs model", v, exp_rd(a[3:2]));
    chk("R2 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_o && n < 5000);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v1;
    int n, hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq low", {31'd0, irq_o}, 32'd0);
    apb_rd(4'h0, v); chk("R1 ctrl", v, 32'd0);
    apb_rd(4'h4, v); chk("R1 period", v, 32'hFFFF_FFFF);
    apb_rd(4'h8, v); chk("R1 status", v, 32'd0);
    apb_rd(4'hC, v); chk("R1 count", v, 32'd0);

    // R3 pulse spacing
    apb_wr(4'h4, 32'd5);
    apb_wr(4'h0, 32'd3);
    wait_irq(n); chk("R3 first gap", n, 5);
    wait_irq(n); chk("R3 gap", n, 5);
    @(negedge clk); chk("R8 pulse one cycle", {31'd0, irq_o}, 32'd0);

    // R2 readback
    apb_rd(4'h0, v); chk("R2 ctrl bit1 reads 0", v, 32'd1);
    apb_rd(4'h4, v); chk("R2 period readback", v, 32'd5);

    // R4 stop holds; R9 status read clears
    apb_wr(4'h0, 32'd0);
    apb_rd(4'hC, v1);
    repeat (10) @(negedge clk);
    apb_rd(4'hC, v); chk("R4 count held", v, v1);
    apb_rd(4'h8, v); chk("R9 status set", v, 32'd1);
    apb_rd(4'h8, v); chk("R9 status cleared by read", v, 32'd0);

    // R10 count not writable
    apb_wr(4'hC, 32'd3);
    apb_rd(4'hC, v); chk("R10 count write ignored", v, v1);

    // R5 count reset
    apb_wr(4'h0, 32'd2);
    apb_rd(4'hC, v); chk("R5 count zero", v, 32'd0);
    apb_rd(4'h4, v); chk("R5 period unchanged", v, 32'd5);
    apb_rd(4'h0, v); chk("R5 still stopped", v, 32'd0);

    // R6 deferred period change
    apb_wr(4'h4, 32'd20);
    apb_wr(4'h0, 32'd3);
    apb_wr(4'h4, 32'd6);
    wait_irq(n); chk("R6 old interval completes", n + 3, 20);
    wait_irq(n); chk("R6 new period after wrap", n, 6);

    // R5 reset loads pending period at once
    apb_wr(4'h4, 32'd9);
    apb_wr(4'h0, 32'd3);
    wait_irq(n); chk("R5 pending period via reset", n, 9);

    // R7 period 0 and 1
    apb_wr(4'h4, 32'd0);
    repeat (12) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); hi += irq_o; end
    chk("R7 period 0 every cycle", hi, 8);
    apb_wr(4'h4, 32'd1);
    repeat (4) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); hi += irq_o; end
    chk("R7 period 1 every cycle", hi, 8);

    // R8 pulse count over a window
    apb_wr(4'h4, 32'd4);
    apb_wr(4'h0, 32'd3);
    hi = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); hi += irq_o; end
    chk("R8 ten pulses in forty cycles", hi, 10);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom % 10;
      case (r)
        0, 1: apb_wr(4'h0, {30'd0, ($urandom % 8) == 0, ($urandom % 5) != 0});
        2:    apb_wr(4'h4, $urandom % 13);
        7:    apb_wr(4'hC, $urandom);
        8, 9: repeat ($urandom % 6) @(negedge clk);
        default: apb_rd({$urandom % 4, 2'b00}, v);
      endcase
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule